// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block takes in characters from an asynchronous serial line that rests high between frames. A falling edge on the line starts a frame. The receiver waits until the middle of the start bit and samples the line again to confirm it. It then samples each data bit, an optional parity bit and one stop bit at their centres. The timing comes from an enable pulse at sixteen times the bit rate, which the block receives from outside. The raw line first passes through a two-stage synchroniser.

A finished character goes to a holding register that the host can read. Four status flags report the result: ready, overrun, parity fault and stop-bit fault. These flags drive two level interrupts, one for received data and one for errors. Each error leaves the holding register in a different state. An overrun throws away the new character and keeps the old one. A parity or stop-bit fault still stores the character and sets the flag beside it.

The host clears a flag in two steps. It first strobes a status read. It then writes 0 to the flag in a clear write. A flag that the host has not seen as 1 in a status read cannot be cleared.

Top module: `arx_receiver`

## Requirements
- R1: The receiver reads `rxd` only on cycles where `os_tick` is high. A 0 seen on the synchronised line while idle starts a frame. The frame is confirmed only if the line is still 0 eight ticks later. Otherwise the receiver goes back to idle and no flag or data changes.
- R2: Data bits arrive least significant bit first, each sampled sixteen ticks after the one before. There are 8 of them, or 7 when `cfg_len7` is 1. In the 7-bit case, bit 7 of `rx_data` reads 0.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. If `cfg_par_odd` is 0, the data bits and the parity bit together must hold an even number of ones; if it is 1, an odd number. A mismatch sets flag bit 2 (parity fault), and the character is still stored.
- R4: A stop bit sampled as 0 sets flag bit 3 (stop-bit fault), and the character is still stored.
- R5: A frame with no fault that ends while flag bit 0 (ready) is 0 stores the character in `rx_data` and sets ready. A frame with a parity or stop-bit fault does not set ready.
- R6: A frame that ends while ready is 1 sets flag bit 1 (overrun). `rx_data` keeps its old value and ready stays 1.
- R7: `irq_rx` is 1 exactly when `irq_en` and ready are both 1. `irq_err` is 1 exactly when `irq_en` is 1 and any of overrun, parity fault or stop-bit fault is 1.
- R8: Flag i clears on a cycle where `fl_wr` is 1 and `fl_wdata[i]` is 0, but only if an earlier `st_rd` strobe found that flag at 1. Writing 1 does nothing. A write of 0 to a flag that was not read as 1 leaves the flag set.
- R9: Error flags stay set through later frames, clean ones included, until the host clears them.
- R10: After reset, `rx_data`, `flags`, `irq_rx` and `irq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Raw serial line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| irq_en | input | 1 | Interrupt enable |
| st_rd | input | 1 | Status read strobe; records which flags the host has seen as 1 |
| fl_wr | input | 1 | Flag clear write strobe |
| fl_wdata | input | 4 | Clear write data; a 0 bit clears a flag already seen as 1 |
| rx_data | output | 8 | Holding register |
| flags | output | 4 | {stop fault, parity fault, overrun, ready} |
| irq_rx | output | 1 | Received-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
A tick counter that slips by one bit period shifts every data bit over, so `rx_data` is wrong as soon as the next frame ends. A frame state that leaves parity or stop handling out of step puts a fault flag on the wrong frame, or misses it, at the end of that frame. A broken seen-bit or clear path shows on `flags` one cycle after the clear write: a flag is either still held or lost. The overrun path shows up when the second of two unread frames ends, through `rx_data` and bit 1 of `flags`.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int ARX_DW  = 8;
  localparam int ARX_NF  = 4;
  localparam int FL_RDY  = 0;
  localparam int FL_OVR  = 1;
  localparam int FL_PAR  = 2;
  localparam int FL_FRM  = 3;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/arx_frame.sv
module arx_frame
  import arx_pkg::*;
#(
  parameter int DW  = ARX_DW,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          len7_i,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          done_q, done_d;
  logic          perr_q, perr_d;
  logic          ferr_q, ferr_d;
  logic [IW-1:0] idx_last;
  logic          at_bit;

  assign idx_last = len7_i ? IW'(DW-2) : IW'(DW-1);
  assign at_bit   = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (rx_i) begin
              state_d = RX_IDLE;
            end else begin
              state_d = RX_DATA;
              idx_d   = '0;
              sh_d    = '0;
              perr_d  = 1'b0;
              ferr_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_bit) begin
            cnt_d       = '0;
            sh_d[idx_q] = rx_i;
            if (idx_q == idx_last) state_d = par_en_i ? RX_PAR : RX_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_bit) begin
            cnt_d   = '0;
            perr_d  = (^sh_q) ^ rx_i ^ par_odd_i;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_bit) begin
            cnt_d   = '0;
            ferr_d  = !rx_i;
            done_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (tick_i) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        idx_q   <= idx_d;
        sh_q    <= sh_d;
        perr_q  <= perr_d;
        ferr_q  <= ferr_d;
      end
    end
  end

  assign done_o = done_q;
  assign byte_o = sh_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
endmodule

// File: rtl/arx_status.sv
module arx_status
  import arx_pkg::*;
#(
  parameter int DW = ARX_DW,
  parameter int NF = ARX_NF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          irq_en_i,
  input  logic          st_rd_i,
  input  logic          fl_wr_i,
  input  logic [NF-1:0] fl_wdata_i,
  output logic [DW-1:0] data_o,
  output logic [NF-1:0] flags_o,
  output logic          irq_rx_o,
  output logic          irq_err_o
);
  logic [DW-1:0] data_q, data_d;
  logic [NF-1:0] flags_q, flags_d;
  logic [NF-1:0] seen_q, seen_d;
  logic [NF-1:0] clr_ok;
  logic          data_en;

  assign clr_ok = {NF{fl_wr_i}} & ~fl_wdata_i & seen_q;

  always_comb begin
    flags_d = flags_q & ~clr_ok;
    data_d  = data_q;
    data_en = 1'b0;
    if (done_i) begin
      if (flags_d[FL_RDY]) begin
        flags_d[FL_OVR] = 1'b1;
      end else begin
        data_d  = byte_i;
        data_en = 1'b1;
        if (perr_i) flags_d[FL_PAR] = 1'b1;
        if (ferr_i) flags_d[FL_FRM] = 1'b1;
        if (!perr_i && !ferr_i) flags_d[FL_RDY] = 1'b1;
      end
    end
    seen_d = (seen_q | (st_rd_i ? flags_q : '0)) & flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      flags_q <= '0;
      seen_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      flags_q <= flags_d;
      seen_q  <= seen_d;
    end
  end

  assign data_o    = data_q;
  assign flags_o   = flags_q;
  assign irq_rx_o  = irq_en_i & flags_q[FL_RDY];
  assign irq_err_o = irq_en_i & (flags_q[FL_OVR] | flags_q[FL_PAR] | flags_q[FL_FRM]);

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && flags_q[FL_RDY] && !fl_wr_i) |=> ($stable(data_q) && flags_q[FL_RDY] && flags_q[FL_OVR])); // R6
  AST_CLEAN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !flags_q[FL_RDY] && !perr_i && !ferr_i) |=> (flags_q[FL_RDY] && data_q == $past(byte_i))); // R5
  AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FL_RDY] && !seen_q[FL_RDY]) |=> flags_q[FL_RDY]); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FL_PAR] && !fl_wr_i) |=> flags_q[FL_PAR]); // R9
endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
  import arx_pkg::*;
#(
  parameter int DW  = ARX_DW,
  parameter int OSR = 16,
  parameter int NF  = ARX_NF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_len7,
  input  logic          irq_en,
  input  logic          st_rd,
  input  logic          fl_wr,
  input  logic [NF-1:0] fl_wdata,
  output logic [DW-1:0] rx_data,
  output logic [NF-1:0] flags,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [1:0]    rst_chain_q;
  logic          rst_n_s;
  logic          rx_s;
  logic          done;
  logic [DW-1:0] frame_byte;
  logic          perr;
  logic          ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= 2'b00;
    else        rst_chain_q <= {rst_chain_q[0], 1'b1};
  end
  assign rst_n_s = rst_chain_q[1];

  arx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (rxd),
    .q_o   (rx_s)
  );

  arx_frame #(.DW(DW), .OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (os_tick),
    .rx_i      (rx_s),
    .par_en_i  (cfg_par_en),
    .par_odd_i (cfg_par_odd),
    .len7_i    (cfg_len7),
    .done_o    (done),
    .byte_o    (frame_byte),
    .perr_o    (perr),
    .ferr_o    (ferr)
  );

  arx_status #(.DW(DW), .NF(NF)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .done_i     (done),
    .byte_i     (frame_byte),
    .perr_i     (perr),
    .ferr_i     (ferr),
    .irq_en_i   (irq_en),
    .st_rd_i    (st_rd),
    .fl_wr_i    (fl_wr),
    .fl_wdata_i (fl_wdata),
    .data_o     (rx_data),
    .flags_o    (flags),
    .irq_rx_o   (irq_rx),
    .irq_err_o  (irq_err)
  );
endmodule

// File: tb/arx_receiver_tb.sv
`timescale 1ns/1ps
module arx_receiver_tb;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic       cfg_par_en, cfg_par_odd, cfg_len7, irq_en;
  logic       st_rd, fl_wr;
  logic [3:0] fl_wdata;
  logic [7:0] rx_data;
  logic [3:0] flags;
  logic       irq_rx, irq_err;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  arx_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_len7(cfg_len7),
    .irq_en(irq_en), .st_rd(st_rd), .fl_wr(fl_wr), .fl_wdata(fl_wdata),
    .rx_data(rx_data), .flags(flags), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  initial begin
    os_tick = 1'b0;
    forever begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        os_tick = (i == 0);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    @(negedge clk);
    rxd = v;
    repeat (clks - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit use_par,
                            input bit pbit, input bit stopv, input int stop_clks);
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < nbits; i++) hold_line(d[i], BITCLK);
    if (use_par) hold_line(pbit, BITCLK);
    hold_line(stopv, stop_clks);
    hold_line(1'b1, BITCLK);
  endtask

  task automatic status_read();
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0;
  endtask

  task automatic flag_write(input logic [3:0] v);
    @(negedge clk); fl_wr = 1'b1; fl_wdata = v;
    @(negedge clk); fl_wr = 1'b0;
  endtask

  task automatic clear_all();
    status_read();
    flag_write(4'b0000);
  endtask

  task automatic t_reset();
    chk(rx_data, 8'h00, "R10 data");
    chk(flags, 4'h0, "R10 flags");
    chk({irq_rx, irq_err}, 2'b00, "R10 irq");
  endtask

  task automatic t_clean();
    send_frame(8'hA5, 8, 0, 0, 1, BITCLK);
    chk(rx_data, 8'hA5, "R2 data lsb first");
    chk(flags, 4'h1, "R5 ready set");
    chk({irq_rx, irq_err}, 2'b10, "R7 rx irq");
  endtask

  task automatic t_clear_rule();
    flag_write(4'b0000);
    chk(flags[0], 1'b1, "R8 unread flag kept");
    status_read();
    flag_write(4'b1111);
    chk(flags[0], 1'b1, "R8 write one no effect");
    flag_write(4'b1110);
    chk(flags, 4'h0, "R8 read then write zero clears");
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 8, 0, 0, 1, BITCLK);
    send_frame(8'h3C, 8, 0, 0, 1, BITCLK);
    chk(rx_data, 8'h11, "R6 old data kept");
    chk(flags, 4'h3, "R6 overrun and ready");
    chk(irq_err, 1'b1, "R7 err irq");
    clear_all();
    chk(flags, 4'h0, "R8 clear after overrun");
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(8'h01, 8, 1, 1'b1, 1, BITCLK);
    chk(flags, 4'h1, "R3 even parity good");
    clear_all();
    send_frame(8'h07, 8, 1, 1'b0, 1, BITCLK);
    chk(rx_data, 8'h07, "R3 data kept on parity fault");
    chk(flags, 4'h4, "R3 parity fault no ready");
    cfg_par_odd = 1'b1;
    send_frame(8'h03, 8, 1, 1'b1, 1, BITCLK);
    chk(flags, 4'h5, "R9 parity flag survives clean odd frame");
    chk(rx_data, 8'h03, "R3 odd parity data");
    clear_all();
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
  endtask

  task automatic t_framing();
    send_frame(8'h5A, 8, 0, 0, 0, 48);
    hold_line(1'b1, 3*BITCLK);
    chk(rx_data, 8'h5A, "R4 data kept on stop fault");
    chk(flags, 4'h8, "R4 stop fault flag");
    clear_all();
  endtask

  task automatic t_false_start();
    hold_line(1'b0, 16);
    hold_line(1'b1, 3*BITCLK);
    chk(flags, 4'h0, "R1 false start no flags");
    chk(rx_data, 8'h5A, "R1 false start no data");
    send_frame(8'h96, 8, 0, 0, 1, BITCLK);
    chk(rx_data, 8'h96, "R1 recovers after false start");
    clear_all();
  endtask

  task automatic t_len7();
    cfg_len7 = 1'b1;
    send_frame(8'hD5, 7, 0, 0, 1, BITCLK);
    chk(rx_data, 8'h55, "R2 seven bit frame");
    chk(flags, 4'h1, "R2 seven bit ready");
    clear_all();
    cfg_len7 = 1'b0;
  endtask

  task automatic t_irq_off();
    irq_en = 1'b0;
    send_frame(8'h42, 8, 0, 0, 1, BITCLK);
    send_frame(8'h43, 8, 0, 0, 1, BITCLK);
    chk(flags, 4'h3, "R6 overrun with irq off");
    chk({irq_rx, irq_err}, 2'b00, "R7 irqs masked");
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk({irq_rx, irq_err}, 2'b11, "R7 irqs unmasked");
    clear_all();
  endtask

  task automatic t_back_to_back();
    send_frame(8'hC3, 8, 0, 0, 1, BITCLK);
    clear_all();
    send_frame(8'h3E, 8, 0, 0, 1, BITCLK);
    chk(rx_data, 8'h3E, "R5 second frame stored");
    chk(flags, 4'h1, "R6 no overrun when serviced");
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1;
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_len7 = 1'b0; irq_en = 1'b1;
    st_rd = 1'b0; fl_wr = 1'b0; fl_wdata = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_clean();
    t_clear_rule();
    t_overrun();
    t_parity();
    t_framing();
    t_false_start();
    t_len7();
    t_irq_off();
    t_back_to_back();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule